// File: doc/BRIEF.md
# LED Blink Controller with Autostop

This block drives one LED output with a programmable blink pattern. A power-of-two prescaler divides an incoming base clock enable into blink ticks. A 12-bit period counter steps on those ticks and wraps after a programmed number of ticks. The LED is lit for the first part of each period, and the duty value sets how many ticks that part lasts.

An optional autostop counter counts completed periods. When it runs out, the controller clears its own enable bit, turns the LED off, and can raise a one-cycle interrupt. Software programs the block through four word-sized registers: the control word, the period, the duty and the autostop count. Reads return the live state. The autostop count therefore shows the periods that remain, and the enable bit shows whether the blinker is still running.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset, `led_out` and `irq_out` are 0 and all four registers read 0.
- R2: The register index `reg_sel` selects one of four registers.
  - 0 is the control word, 7 bits wide. Bits [3:0] hold the prescale, bit 4 is the enable, bit 5 is the autostop enable and bit 6 is the interrupt mask.
  - 1 is the period (12 bits), 2 is the duty (12 bits) and 3 is the autostop count (16 bits).
  - Reads return the stored value, and unused upper bits read 0.
- R3: A prescale value n gives one blink tick every 2^(13-n) cycles in which `base_en` is high. While `base_en` is low, the prescaler and the period counter hold their values.
- R4: A prescale value above 13 behaves as 13 (one tick for each base enable). The raw value is still returned on read.
- R5: A period value P gives a period of P ticks, and P=0 gives a period of 1 tick. The LED is high while the tick position within the period is below the duty value, and low otherwise.
- R6: When duty is greater than or equal to period, the LED stays high for as long as the block is enabled.
- R7: When the enable bit is 0, `led_out` is 0 and the prescaler and the period counter are held at zero.
- R8: A write to any register restarts the prescaler and the period counter from zero. The new pattern starts in the cycle after the write.
- R9: With autostop enabled, the count decreases by 1 at the end of each period. The end of the period in which the count reaches 0 has these effects:
  - The enable bit clears and the LED goes off.
  - The count reads 0.
  - A count that is already 0 or 1 stops the blinker at the next period end.
- R10: When autostop stops the blinker, `irq_out` pulses high for exactly one cycle, unless the interrupt mask bit is 1.
- R11: With autostop disabled, the autostop count never changes except through a write, and blinking continues indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_en | input | 1 | Base time-base clock enable |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index (byte offset divided by 4) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the register at `reg_sel` |
| led_out | output | 1 | LED drive, active high |
| irq_out | output | 1 | One-cycle autostop completion pulse |

## Verification
Assertions are checked in every cycle:
- The prescaler count and the period position never go past their terminal values.
- The period position is zero in the cycle after any register write.
- The interrupt lasts only one cycle, and when it fires the LED is dark, the enable bit is clear and the count is zero.
- The autostop count stays fixed while autostop is off.

Only the bench scenarios can show the full on/off waveform for each prescale and period/duty combination, and the clamping of oversized prescale values. They also show the stall under a low base enable, the exact cycle in which autostop ends the pattern, and the masked case, in which the blinker stops without an interrupt.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    // Width of the prescale field in the control word
    localparam int SHIFT_W  = 4;
    // Width of the control word
    localparam int CTRL_W   = 7;

    // Control word, packed so that bit 6 is the mask and bits [3:0] the prescale
    typedef struct packed {
        logic               irq_mask;
        logic               auto_en;
        logic               run;
        logic [SHIFT_W-1:0] shift;
    } tb_ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_STOP   = 2'd3
    } reg_sel_e;

    // Limit the prescale field to the largest legal value
    function automatic logic [SHIFT_W-1:0] clamp_shift(
        input logic [SHIFT_W-1:0] raw,
        input logic [SHIFT_W-1:0] lim
    );
        return (raw > lim) ? lim : raw;
    endfunction

endpackage

// File: rtl/led_prescaler.sv
module led_prescaler
    import led_blink_pkg::*;
#(
    parameter int MAX_SHIFT = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               run,
    input  logic               base_en,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PW = MAX_SHIFT;

    logic [SHIFT_W:0] sh_amt;
    logic [PW:0]      span;
    logic [PW-1:0]    last;
    logic [PW-1:0]    cnt_q;

    always_comb begin
        sh_amt = (SHIFT_W+1)'(MAX_SHIFT) - {1'b0, shift};
        span   = {{PW{1'b0}}, 1'b1} << sh_amt;
        last   = PW'(span - 1'b1);
        tick   = run && base_en && !restart && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt_q <= '0;
        end else if (base_en) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

    // R7
    pre_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/led_period_gen.sv
module led_period_gen #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             period_end,
    output logic             led
);
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last       = (period == '0) ? '0 : period - 1'b1;
        period_end = tick && (pos_q == last);
        led        = run && ((duty >= period) || (pos_q < duty));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= period_end ? '0 : pos_q + 1'b1;
        end
    end

    // R5
    pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= last);

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pos_q == '0));

endmodule

// File: rtl/led_blink_regs.sv
module led_blink_regs
    import led_blink_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int STOP_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              period_end,
    output tb_ctrl_t          ctrl,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  duty,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    reg_sel_e          sel;
    logic [STOP_W-1:0] remain_q;
    logic              stop_evt;

    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        stop_evt = period_end && ctrl.auto_en && ctrl.run && !wr_en;
        case (sel)
            SEL_CTRL:   rd_data = DATA_W'(ctrl);
            SEL_PERIOD: rd_data = DATA_W'(period);
            SEL_DUTY:   rd_data = DATA_W'(duty);
            default:    rd_data = DATA_W'(remain_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            period   <= '0;
            duty     <= '0;
            remain_q <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_en) begin
                case (sel)
                    SEL_CTRL:   ctrl     <= tb_ctrl_t'(wr_data[CTRL_W-1:0]);
                    SEL_PERIOD: period   <= wr_data[CNT_W-1:0];
                    SEL_DUTY:   duty     <= wr_data[CNT_W-1:0];
                    default:    remain_q <= wr_data[STOP_W-1:0];
                endcase
            end else if (stop_evt) begin
                if (remain_q <= STOP_W'(1)) begin
                    remain_q <= '0;
                    ctrl.run <= 1'b0;
                    irq      <= !ctrl.irq_mask;
                end else begin
                    remain_q <= remain_q - 1'b1;
                end
            end
        end
    end

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9
    stop_state_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!ctrl.run && remain_q == '0));

    // R11
    remain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ctrl.auto_en) |=> (remain_q == $past(remain_q)));

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int STOP_W    = 16,
    parameter int DATA_W    = 16,
    parameter int MAX_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_en,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              led_out,
    output logic              irq_out
);
    tb_ctrl_t           ctrl;
    logic [CNT_W-1:0]   period;
    logic [CNT_W-1:0]   duty;
    logic [SHIFT_W-1:0] eff_shift;
    logic               tick;
    logic               period_end;

    assign eff_shift = clamp_shift(ctrl.shift, SHIFT_W'(MAX_SHIFT));

    led_blink_regs #(
        .CNT_W (CNT_W),
        .STOP_W(STOP_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .period_end(period_end),
        .ctrl      (ctrl),
        .period    (period),
        .duty      (duty),
        .irq       (irq_out),
        .rd_data   (rd_data)
    );

    led_prescaler #(
        .MAX_SHIFT(MAX_SHIFT)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(wr_en),
        .run    (ctrl.run),
        .base_en(base_en),
        .shift  (eff_shift),
        .tick   (tick)
    );

    led_period_gen #(
        .CNT_W(CNT_W)
    ) u_per (
        .clk       (clk),
        .rst       (rst),
        .restart   (wr_en),
        .run       (ctrl.run),
        .tick      (tick),
        .period    (period),
        .duty      (duty),
        .period_end(period_end),
        .led       (led_out)
    );

    // R10
    irq_dark_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> !led_out);

endmodule

// File: tb/sim_led_blink_ctrl.sv
module sim_led_blink_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        led_out;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_blink_ctrl u0 (
        .clk    (clk),
        .rst    (rst),
        .base_en(base_en),
        .wr_en  (wr_en),
        .reg_sel(reg_sel),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .led_out(led_out),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input int sel, input int data);
        reg_sel = 2'(sel);
        wr_data = 16'(data);
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int sel, output int val);
        reg_sel = 2'(sel);
        #1;
        val = int'(rd_data);
    endtask

    function automatic int exp_led(int k, int p, int d, int n);
        int eff = (n > 13) ? 13 : n;
        int dv  = 1 << (13 - eff);
        int pl  = (p == 0) ? 1 : p;
        int ph  = (k / dv) % pl;
        return ((d >= p) || (ph < d)) ? 1 : 0;
    endfunction

    task automatic run_pattern(input string tag, input int p, input int d,
                               input int n, input int cycles);
        wr(1, p);
        wr(2, d);
        wr(0, 16 | n);
        for (int k = 0; k < cycles; k++) begin
            if (k > 0) @(negedge clk);
            chk(tag, int'(led_out), exp_led(k, p, d, n));
        end
        wr(0, 0);
    endtask

    task automatic t_reset;
        int v;
        chk("R1 led", int'(led_out), 0);
        chk("R1 irq", int'(irq_out), 0);
        for (int s = 0; s < 4; s++) begin
            rd(s, v);
            chk("R1 reg", v, 0);
        end
    endtask

    task automatic t_regmap;
        int v;
        wr(0, 16'hFFCF);
        wr(1, 16'hF123);
        wr(2, 16'hA456);
        wr(3, 16'hBEEF);
        rd(0, v); chk("R2 ctrl", v, 16'h004F);
        rd(1, v); chk("R2 period", v, 16'h0123);
        rd(2, v); chk("R2 duty", v, 16'h0456);
        rd(3, v); chk("R2 count", v, 16'hBEEF);
        chk("R2 led off while disabled", int'(led_out), 0);
        @(negedge clk);
        wr(0, 0); wr(3, 0);
    endtask

    task automatic t_clamp;
        int v;
        run_pattern("R4 clamp 15", 3, 1, 15, 9);
        wr(0, 16'h000F);
        rd(0, v);
        chk("R4 raw readback", v, 16'h000F);
        @(negedge clk);
        wr(0, 0);
    endtask

    task automatic t_disabled;
        wr(1, 4);
        wr(2, 2);
        wr(0, 16'h000D);
        for (int k = 0; k < 6; k++) begin
            if (k > 0) @(negedge clk);
            chk("R7 disabled", int'(led_out), 0);
        end
    endtask

    task automatic t_stall;
        int expv [4] = '{0, 1, 0, 0};
        wr(1, 4);
        wr(2, 2);
        base_en = 1'b0;
        wr(0, 16'h001D);
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(negedge clk);
            chk("R3 stall", int'(led_out), 1);
        end
        base_en = 1'b1;
        // position after successive edges: 1,2,3,0
        expv = '{1, 0, 0, 1};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R3 resume", int'(led_out), expv[k]);
        end
        wr(0, 0);
    endtask

    task automatic t_restart;
        wr(1, 4);
        wr(2, 2);
        wr(0, 16'h001D);
        @(negedge clk);
        @(negedge clk);
        chk("R8 before write", int'(led_out), 0);
        wr(2, 2);
        chk("R8 restarted pos0", int'(led_out), 1);
        @(negedge clk);
        chk("R8 restarted pos1", int'(led_out), 1);
        @(negedge clk);
        chk("R8 restarted pos2", int'(led_out), 0);
        wr(0, 0);
    endtask

    task automatic t_autostop(input bit masked);
        int v;
        string tg = masked ? "R10 masked" : "R9 R10 autostop";
        wr(1, 3);
        wr(2, 1);
        wr(3, 2);
        wr(0, masked ? 16'h007D : 16'h003D);
        for (int k = 0; k < 10; k++) begin
            if (k > 0) @(negedge clk);
            chk({tg, " led"}, int'(led_out), (k < 6 && (k % 3) == 0) ? 1 : 0);
            chk({tg, " irq"}, int'(irq_out), (!masked && k == 6) ? 1 : 0);
        end
        rd(0, v); chk("R9 enable cleared", v, masked ? 16'h006D : 16'h002D);
        rd(3, v); chk("R9 count zero", v, 0);
        @(negedge clk);
        wr(0, 0);
    endtask

    task automatic t_no_autostop;
        int v;
        wr(1, 3);
        wr(2, 1);
        wr(3, 2);
        wr(0, 16'h001D);
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            chk("R11 led", int'(led_out), ((k % 3) == 0) ? 1 : 0);
            chk("R11 irq", int'(irq_out), 0);
        end
        rd(3, v); chk("R11 count held", v, 2);
        @(negedge clk);
        wr(0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        run_pattern("R5 p4 d2", 4, 2, 13, 12);
        run_pattern("R5 p5 d1", 5, 1, 13, 15);
        run_pattern("R3 n12", 2, 1, 12, 12);
        run_pattern("R3 n11", 3, 2, 11, 24);
        run_pattern("R3 n0 slow", 2, 1, 0, 20000);
        t_clamp();
        run_pattern("R6 duty over period", 3, 5, 13, 9);
        run_pattern("R6 period zero", 0, 0, 13, 5);
        t_disabled();
        t_stall();
        t_restart();
        t_autostop(1'b0);
        t_autostop(1'b1);
        t_no_autostop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule